// File: doc/BRIEF.md
# EEPROM Page-Write Latch and Write-Cycle Controller

This block sits behind the two-wire serial slave of a small serial EEPROM. It gathers the data bytes of a write transfer into a one-page latch. When the transfer closes at the one legal instant, it commits the latched bytes to a 512 x 8 array through a timed internal programming cycle. The slave decodes the bus. It reports to this block when an address is loaded, when a data bit or a data byte has been taken, when a data acknowledge has finished, and when a START or a STOP is seen.

While the programming cycle runs, `busy_o` is high. The slave uses that flag to refuse its address acknowledge, and the block itself ignores every strobe. A master polls for completion by addressing the device until it is acknowledged again. The array lives outside the block, and the block drives its write port. A write-protect input blocks every commit.

Programming starts only when a STOP arrives right after the acknowledge of a data byte, before any bit of a further byte. A START or a STOP at any other moment throws the latched bytes away.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset `busy_o` and `mem_we_o` are low, and they stay low until a write transfer is committed.
- R2: Each accepted data byte goes into the latch entry given by the column counter, and the counter then steps by one. The counter is modulo 16, so byte 17 onward wrap inside the same page and overwrite earlier entries.
- R3: An address load takes a 9-bit address. Bits [8:4] select the page (0 to 31) and bits [3:0] set the starting column. Every array write of the following cycle goes to address {page, column}.
- R4: A STOP that arrives after a data acknowledge, with no data bit in between, starts a programming cycle if at least one byte is latched and write-protect is low. `busy_o` rises in the cycle after the STOP and stays high for exactly WCYC_CLKS cycles.
- R5: During the cycle, each latched entry is written exactly once, in ascending column order, within the first 16 cycles of `busy_o`. `mem_we_o` is never high while `busy_o` is low.
- R6: Latch entries that received no byte during the transfer produce no write, so those array bytes keep their old contents.
- R7: A START, or a STOP that follows a data bit rather than an acknowledge, discards the latched bytes and starts no cycle. A later one-byte transfer then writes only that one byte.
- R8: With write-protect high at the STOP, no cycle starts and no array write occurs, and the latched bytes are discarded.
- R9: While `busy_o` is high, all strobes are ignored. The cycle length is unchanged, no new cycle follows, and nothing is latched.
- R10: A STOP after an address load with no data byte starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_i | input | 1 | Write protect, high blocks commits |
| addr_load_i | input | 1 | Pulse: load start address |
| addr_i | input | 9 | Start address (page and column) |
| bit_stb_i | input | 1 | Pulse: a data bit was sampled |
| byte_stb_i | input | 1 | Pulse: a full data byte is on `byte_i` |
| byte_i | input | 8 | Received data byte |
| data_ack_i | input | 1 | Pulse: acknowledge of a data byte finished |
| start_i | input | 1 | Pulse: START or repeated START seen |
| stop_i | input | 1 | Pulse: STOP seen |
| busy_o | output | 1 | Programming cycle in progress |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | 9 | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
The assertions assume that each strobe is a single-cycle pulse and that the strobes arrive in bus order. A transfer is an address load, then bit and byte strobes, then the data acknowledge, then at most one START or STOP in a cycle. They also assume that `wp_i` is steady around a STOP. The bench drives only such well-formed sequences, one strobe per cycle on falling edges. It deliberately fires strobes during `busy_o`, which the block must ignore. The sweep covers every starting column with 1 to 18 bytes, so wraps and partial pages are both exercised.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
   typedef enum logic {
      PS_IDLE = 1'b0,
      PS_PROG = 1'b1
   } prog_state_e;
endpackage

// File: rtl/eepw_page_latch.sv
module eepw_page_latch #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int COL_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              col_load,
   input  logic [COL_W-1:0]  col_in,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [COL_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              any_valid
);
   logic [COL_W-1:0]  col_q;
   logic [DEPTH-1:0]  vld_w;
   logic [DATA_W-1:0] ent_w [DEPTH];

   if ((1 << COL_W) != DEPTH) begin : g_bad_depth
      $error("page latch depth must be a power of two");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        col_q <= '0;
      else if (col_load) col_q <= col_in;
      else if (wr)       col_q <= col_q + 1'b1;
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      logic              v_q;
      logic [DATA_W-1:0] d_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= '0;
         end else if (clear) begin
            v_q <= 1'b0;
         end else if (wr && col_q == COL_W'(g)) begin
            v_q <= 1'b1;
            d_q <= wdata;
         end
      end
      assign vld_w[g] = v_q;
      assign ent_w[g] = d_q;
   end

   assign rd_data   = ent_w[rd_idx];
   assign rd_valid  = vld_w[rd_idx];
   assign any_valid = |vld_w;

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !any_valid);  // R7
   AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !clear && !col_load) |=> any_valid);  // R2
endmodule

// File: rtl/eepw_wcycle_timer.sv
module eepw_wcycle_timer
   import eepw_pkg::*;
#(
   parameter int CYCLES = 500000,
   parameter int SWEEP  = 16,
   parameter int IDX_W  = 4,
   localparam int CNT_W = $clog2(CYCLES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   output logic             busy,
   output logic             sweep,
   output logic [IDX_W-1:0] idx,
   output logic             done
);
   prog_state_e      st_q;
   logic [CNT_W-1:0] cnt_q;

   if (CYCLES < SWEEP || CNT_W < IDX_W) begin : g_bad_cycles
      $error("write cycle must be at least one page sweep long");
   end

   assign busy  = (st_q == PS_PROG);
   assign done  = busy && (cnt_q == CNT_W'(CYCLES - 1));
   assign sweep = busy && (cnt_q < CNT_W'(SWEEP));
   assign idx   = cnt_q[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= PS_IDLE;
         cnt_q <= '0;
      end else if (st_q == PS_IDLE) begin
         cnt_q <= '0;
         if (go) st_q <= PS_PROG;
      end else if (done) begin
         st_q  <= PS_IDLE;
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt_q <= CNT_W'(CYCLES - 1)));  // R4
   AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);  // R4
   AST_GO_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !busy) |=> (busy && cnt_q == '0));  // R4
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
   parameter int ADDR_W     = 9,
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 16,
   parameter int WCYC_CLKS  = 500000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_i,
   input  logic              addr_load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              bit_stb_i,
   input  logic              byte_stb_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              data_ack_i,
   input  logic              start_i,
   input  logic              stop_i,
   output logic              busy_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o
);
   localparam int COL_W  = $clog2(PAGE_BYTES);
   localparam int PAGE_W = ADDR_W - COL_W;

   if (PAGE_W < 1) begin : g_bad_addr
      $error("address must be wider than the column index");
   end

   logic              load_g, bit_g, byte_g, ack_g, start_g, stop_g;
   logic              armed_q, commit, lat_clear, done;
   logic [PAGE_W-1:0] page_q;
   logic [COL_W-1:0]  idx;
   logic              sweep, rd_valid, any_valid;
   logic [DATA_W-1:0] rd_data;

   // every strobe is dropped while a programming cycle runs
   assign load_g  = addr_load_i & ~busy_o;
   assign bit_g   = bit_stb_i   & ~busy_o;
   assign byte_g  = byte_stb_i  & ~busy_o;
   assign ack_g   = data_ack_i  & ~busy_o;
   assign start_g = start_i     & ~busy_o;
   assign stop_g  = stop_i      & ~busy_o;

   assign commit    = stop_g & armed_q & any_valid & ~wp_i;
   assign lat_clear = load_g | start_g | (stop_g & ~commit) | done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 armed_q <= 1'b0;
      else if (load_g | bit_g | start_g | stop_g) armed_q <= 1'b0;
      else if (ack_g)                             armed_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      page_q <= '0;
      else if (load_g) page_q <= addr_i[ADDR_W-1 -: PAGE_W];
   end

   eepw_page_latch #(.DATA_W(DATA_W), .DEPTH(PAGE_BYTES)) i_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (lat_clear),
      .col_load  (load_g),
      .col_in    (addr_i[COL_W-1:0]),
      .wr        (byte_g),
      .wdata     (byte_i),
      .rd_idx    (idx),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid),
      .any_valid (any_valid)
   );

   eepw_wcycle_timer #(.CYCLES(WCYC_CLKS), .SWEEP(PAGE_BYTES), .IDX_W(COL_W)) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (commit),
      .busy  (busy_o),
      .sweep (sweep),
      .idx   (idx),
      .done  (done)
   );

   assign mem_we_o    = sweep & rd_valid;
   assign mem_addr_o  = {page_q, idx};
   assign mem_wdata_o = rd_data;

   AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> busy_o);  // R5
   AST_START_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(stop_i && armed_q));  // R4
   AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> !$past(wp_i));  // R8
   AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(page_q));  // R9
endmodule

// File: tb/test_eeprom_page_writer.sv
module test_eeprom_page_writer;
   localparam int AW = 9, DW = 8, PB = 16, WC = 40;
   localparam int NMEM = 1 << AW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wp_i = 1'b0, addr_load_i = 1'b0, bit_stb_i = 1'b0, byte_stb_i = 1'b0;
   logic data_ack_i = 1'b0, start_i = 1'b0, stop_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic [DW-1:0] byte_i = '0;
   logic busy_o, mem_we_o;
   logic [AW-1:0] mem_addr_o;
   logic [DW-1:0] mem_wdata_o;

   int n_chk = 0, n_fail = 0;
   int busy_cnt = 0, wr_cnt = 0, bad_we = 0;
   logic [DW-1:0] act_mem [NMEM];
   logic [DW-1:0] exp_mem [NMEM];

   always #10 clk = ~clk;

   eeprom_page_writer #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .WCYC_CLKS(WC))
   i_eeprom_page_writer (.*);

   always begin
      @(negedge clk);
      #1;
      if (busy_o) busy_cnt++;
      if (mem_we_o) begin
         if (!busy_o) bad_we++;
         act_mem[mem_addr_o] = mem_wdata_o;
         wr_cnt++;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk); s = 1'b1;
      @(negedge clk); s = 1'b0;
   endtask

   function automatic logic [7:0] dval(input int seed, input int k);
      return 8'((seed * 31 + k * 13 + 7) & 255);
   endfunction

   // mode 0: proper STOP, 1: data bit then STOP, 2: START then STOP, 3: STOP without bytes
   task automatic xfer(input int addr, input int n, input int seed, input bit wpv,
                       input int mode, input bit poke, input string req);
      logic [7:0] lat [PB];
      bit vld [PB];
      bit commit;
      int col, mism, exp_wr;
      for (int c = 0; c < PB; c++) vld[c] = 0;
      busy_cnt = 0; wr_cnt = 0; bad_we = 0;
      wp_i = wpv;
      @(negedge clk); addr_i = AW'(addr); addr_load_i = 1'b1;
      @(negedge clk); addr_load_i = 1'b0;
      col = addr % PB;
      for (int k = 0; k < n; k++) begin
         pulse(bit_stb_i);
         @(negedge clk); byte_i = dval(seed, k); byte_stb_i = 1'b1;
         @(negedge clk); byte_stb_i = 1'b0; data_ack_i = 1'b1;
         @(negedge clk); data_ack_i = 1'b0;
         lat[col] = dval(seed, k); vld[col] = 1; col = (col + 1) % PB;
      end
      if (mode == 1) pulse(bit_stb_i);
      if (mode == 2) pulse(start_i);
      pulse(stop_i);
      commit = (mode == 0) && (n > 0) && !wpv;
      exp_wr = 0;
      if (commit)
         for (int c = 0; c < PB; c++)
            if (vld[c]) begin
               exp_mem[(addr / PB) * PB + c] = lat[c];
               exp_wr++;
            end
      for (int t = 0; t < WC + 6; t++) begin
         @(negedge clk);
         if (poke && t == 4) begin
            addr_i = AW'((addr + 5) % NMEM); addr_load_i = 1'b1; byte_stb_i = 1'b1;
            byte_i = 8'hA5; data_ack_i = 1'b1; wp_i = 1'b0;
         end else if (poke && t == 5) begin
            addr_load_i = 1'b0; byte_stb_i = 1'b0; data_ack_i = 1'b0; stop_i = 1'b1;
         end else if (poke && t == 6) begin
            stop_i = 1'b0; start_i = 1'b1;
         end else begin
            start_i = 1'b0;
         end
      end
      wp_i = 1'b0;
      check(busy_cnt == (commit ? WC : 0), {req, " busy length"}, busy_cnt, commit ? WC : 0);
      check(wr_cnt == exp_wr, {req, " write count"}, wr_cnt, exp_wr);
      check(bad_we == 0, "R5 write outside busy", bad_we, 0);
      mism = 0;
      for (int a = 0; a < NMEM; a++) if (act_mem[a] != exp_mem[a]) mism++;
      check(mism == 0, {req, " array contents"}, mism, 0);
   endtask

   initial begin
      for (int a = 0; a < NMEM; a++) begin
         act_mem[a] = '0;
         exp_mem[a] = '0;
      end
      // R1: outputs are quiet in reset and right after it
      #35;
      check(busy_o == 1'b0, "R1 busy in reset", int'(busy_o), 0);
      check(mem_we_o == 1'b0, "R1 write enable in reset", int'(mem_we_o), 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(busy_o == 1'b0 && mem_we_o == 1'b0, "R1 idle after reset",
            int'(busy_o) + int'(mem_we_o), 0);
      // R2 R3 R4 R5 R6: every start column, 1 to 18 bytes (R2 wrap from 17 on)
      for (int c = 0; c < PB; c++)
         for (int n = 1; n <= 18; n++)
            xfer(((c * 7 + n) % 32) * PB + c, n, c * 20 + n, 1'b0, 0, 1'b0, "R2 R3 R4 R5 R6");
      // R7: data bit before STOP, then proof the latch was emptied
      xfer(3 * PB + 2, 5, 900, 1'b0, 1, 1'b0, "R7 bit-then-stop");
      xfer(3 * PB + 9, 1, 901, 1'b0, 0, 1'b0, "R7 follow-up");
      // R7: repeated START discards
      xfer(4 * PB + 0, 16, 902, 1'b0, 2, 1'b0, "R7 start abort");
      xfer(4 * PB + 15, 1, 903, 1'b0, 0, 1'b0, "R7 follow-up");
      // R8: write protect
      xfer(5 * PB + 4, 6, 904, 1'b1, 0, 1'b0, "R8 protected");
      xfer(5 * PB + 1, 1, 905, 1'b0, 0, 1'b0, "R8 follow-up");
      // R10: address only
      xfer(6 * PB + 3, 0, 906, 1'b0, 3, 1'b0, "R10 address only");
      // R9: strobes during busy are ignored
      xfer(7 * PB + 6, 3, 907, 1'b0, 0, 1'b1, "R9 poked cycle");
      xfer(7 * PB + 12, 1, 908, 1'b0, 0, 1'b0, "R9 follow-up");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule